// File: doc/BRIEF.md
# Interrupt Status Aggregation Register

This block collects a chip's top-level interrupt sources into one status word and drives a single interrupt line to the CPU. There are two kinds of status bit. The low bits are event bits. Each one latches a one-cycle pulse from its source and holds it until the host clears it. The upper bits are level bits. Each one is a registered copy of a source that lives in some sub-block, and it clears only when that sub-block clears it.

A host reaches the block through a single-cycle register strobe. Reading the primary status offset returns the word and clears every event bit in the same cycle. Reading the alias offset returns the same word and leaves it untouched. A mask register can stop any bit from reaching the interrupt line while the status still records the event. An acknowledge register clears chosen event bits: a 1 clears that bit and a 0 does nothing. A pulse that arrives in the same cycle as a clear is never lost.

Read data is registered. It appears the cycle after the read strobe and holds until the next read. Unused offsets read as zero, and so does the acknowledge offset.

Top module: `irq_status_agg`

## Requirements
- R1: After reset, every status bit is 0, every mask bit is 1 (mask reads 0xFFFF with the default widths), `irq_o` is 0 and `bus_rdata` is 0.
- R2: A pulse on `evt_in[i]` sets status bit i at the next clock edge. The bit then stays set until a primary read or an acknowledge clears it.
- R3: A read at `OFS_STAT` returns the status word, zero-extended, on `bus_rdata` one cycle after the strobe. The same edge clears status bits 0 to NUM_EVT-1.
- R4: A read at `OFS_ALIAS` returns the same word one cycle after the strobe and clears no bit.
- R5: Status bit NUM_EVT+j equals `lvl_in[j]` delayed by one clock. No read and no acknowledge changes it.
- R6: Setting mask bit i keeps status bit i from raising `irq_o`. The status bit still records the event and can still be read.
- R7: A write at `OFS_ACK` clears event bit i where `bus_wdata[i]` is 1. A 0 in the write data leaves the bit as it was. Write data bits at or above NUM_EVT have no effect on any bit.
- R8: When an event pulse meets a primary read or an acknowledge of the same bit in one cycle, the bit is set after that edge.
- R9: `irq_o` in cycle n+1 is the OR over all bits of (status AND NOT mask) as they stood in cycle n.
- R10: A write at `OFS_MASK` loads `bus_wdata[STAT_W-1:0]` into the mask. A read at `OFS_MASK` returns the mask one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | NUM_EVT | One-cycle event pulses for the clearing-class bits |
| lvl_in | input | NUM_LVL | Level sources for the upper status bits |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by bus_sel |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Registered interrupt line to the CPU |

## Verification
The bound checker watches these rules on every clock:
- event capture, including when a pulse meets a clear;
- a primary read leaving only the new pulses behind;
- an alias read keeping the status;
- an acknowledge clearing the bits it names;
- the level bits tracking their sources;
- a fully masked word keeping the interrupt line low.

Some behaviour only the bench's scenarios can show: the actual read values at each offset, the mask read-back, a zero acknowledge leaving bits alone, and the interrupt line rising once a pending bit is unmasked. For these the bench compares the ports against its own model every cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   // One-hot decode of a single-cycle register access
   typedef struct packed {
      logic rd_pri;   // read at status offset, clears event bits
      logic rd_ali;   // read at alias offset, no side effect
      logic rd_msk;   // read of mask
      logic wr_msk;   // write of mask
      logic wr_ack;   // write-one-to-clear acknowledge
   } bus_dec_t;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
   import irq_agg_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int OFS_STAT  = 'h00,
   parameter int OFS_MASK  = 'h04,
   parameter int OFS_ACK   = 'h08,
   parameter int OFS_ALIAS = 'h0C
) (
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output bus_dec_t          dec
);

   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFS_ACK);
   localparam logic [ADDR_W-1:0] A_ALIAS = ADDR_W'(OFS_ALIAS);

   logic rd, wr;

   always_comb begin
      rd = bus_sel && !bus_wr;
      wr = bus_sel &&  bus_wr;
      dec.rd_pri = rd && (bus_addr == A_STAT);
      dec.rd_ali = rd && (bus_addr == A_ALIAS);
      dec.rd_msk = rd && (bus_addr == A_MASK);
      dec.wr_msk = wr && (bus_addr == A_MASK);
      dec.wr_ack = wr && (bus_addr == A_ACK);
   end

endmodule

// File: rtl/irq_evt_latch.sv
module irq_evt_latch #(
   parameter int NUM_EVT = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_in,
   input  logic               clr_all,
   input  logic [NUM_EVT-1:0] ack_vec,
   output logic [NUM_EVT-1:0] evt_q
);

   // One sticky flop per event; a new pulse beats any clear in the same cycle
   for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
      logic clr_i;
      assign clr_i = clr_all | ack_vec[i];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         evt_q[i] <= 1'b0;
         else if (evt_in[i]) evt_q[i] <= 1'b1;
         else if (clr_i)     evt_q[i] <= 1'b0;
      end
   end

endmodule

// File: rtl/irq_lvl_track.sv
module irq_lvl_track #(
   parameter int NUM_LVL = 9,
   parameter bit LVL_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_LVL-1:0] lvl_in,
   output logic [NUM_LVL-1:0] lvl_q
);

   if (LVL_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl_q <= '0;
         else        lvl_q <= lvl_in;
      end
   end else begin : g_pass
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign lvl_q      = lvl_in;
   end

endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen #(
   parameter int STAT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] stat,
   input  logic [STAT_W-1:0] mask,
   output logic              irq_o
);

   logic [STAT_W-1:0] pend;

   assign pend = stat & ~mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= |pend;
   end

endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
   import irq_agg_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int NUM_EVT   = 7,
   parameter int NUM_LVL   = 9,
   parameter bit LVL_REG   = 1'b1,
   parameter int OFS_STAT  = 'h00,
   parameter int OFS_MASK  = 'h04,
   parameter int OFS_ACK   = 'h08,
   parameter int OFS_ALIAS = 'h0C
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_in,
   input  logic [NUM_LVL-1:0] lvl_in,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_o
);

   localparam int STAT_W = NUM_EVT + NUM_LVL;

   // Elaboration-time parameter checks
   if (NUM_EVT < 1 || NUM_LVL < 1) begin : g_bad_count
      $error("irq_status_agg: NUM_EVT and NUM_LVL must be at least 1");
   end
   if (STAT_W > DATA_W) begin : g_bad_width
      $error("irq_status_agg: status word wider than data bus");
   end
   if (OFS_STAT == OFS_ALIAS || OFS_STAT == OFS_MASK || OFS_STAT == OFS_ACK ||
       OFS_ALIAS == OFS_MASK || OFS_ALIAS == OFS_ACK || OFS_MASK == OFS_ACK) begin : g_bad_ofs
      $error("irq_status_agg: register offsets must be distinct");
   end

   bus_dec_t           dec;
   logic [NUM_EVT-1:0] evt_q;
   logic [NUM_EVT-1:0] ack_vec;
   logic [NUM_LVL-1:0] lvl_q;
   logic [STAT_W-1:0]  stat_w;
   logic [STAT_W-1:0]  mask_q;
   logic [DATA_W-1:0]  rdata_d;

   irq_bus_decode #(
      .ADDR_W(ADDR_W), .OFS_STAT(OFS_STAT), .OFS_MASK(OFS_MASK),
      .OFS_ACK(OFS_ACK), .OFS_ALIAS(OFS_ALIAS)
   ) u_dec (
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .dec(dec)
   );

   assign ack_vec = dec.wr_ack ? bus_wdata[NUM_EVT-1:0] : '0;

   irq_evt_latch #(.NUM_EVT(NUM_EVT)) u_evt (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
      .clr_all(dec.rd_pri), .ack_vec(ack_vec), .evt_q(evt_q)
   );

   irq_lvl_track #(.NUM_LVL(NUM_LVL), .LVL_REG(LVL_REG)) u_lvl (
      .clk(clk), .rst_n(rst_n), .lvl_in(lvl_in), .lvl_q(lvl_q)
   );

   assign stat_w = {lvl_q, evt_q};

   // Mask: reset to all ones so every source starts masked
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mask_q <= '1;
      else if (dec.wr_msk) mask_q <= bus_wdata[STAT_W-1:0];
   end

   // Registered read data, updated on any read, held otherwise
   always_comb begin
      rdata_d = '0;
      if (dec.rd_pri || dec.rd_ali) rdata_d = DATA_W'(stat_w);
      else if (dec.rd_msk)          rdata_d = DATA_W'(mask_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    bus_rdata <= '0;
      else if (bus_sel && !bus_wr)   bus_rdata <= rdata_d;
   end

   irq_line_gen #(.STAT_W(STAT_W)) u_irq (
      .clk(clk), .rst_n(rst_n), .stat(stat_w), .mask(mask_q), .irq_o(irq_o)
   );

   if (STAT_W < DATA_W) begin : g_wdata_hi
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata[DATA_W-1:STAT_W];
   end

endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk #(
   parameter int ADDR_W    = 8,
   parameter int NUM_EVT   = 7,
   parameter int NUM_LVL   = 9,
   parameter bit LVL_REG   = 1'b1,
   parameter int OFS_STAT  = 'h00,
   parameter int OFS_ACK   = 'h08,
   parameter int OFS_ALIAS = 'h0C
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [NUM_EVT-1:0]         evt_in,
   input logic [NUM_LVL-1:0]         lvl_in,
   input logic                       bus_sel,
   input logic                       bus_wr,
   input logic [ADDR_W-1:0]          bus_addr,
   input logic [NUM_EVT-1:0]         ack_data,
   input logic                       irq_o,
   input logic [NUM_EVT+NUM_LVL-1:0] stat,
   input logic [NUM_EVT+NUM_LVL-1:0] mask
);

   localparam int STAT_W = NUM_EVT + NUM_LVL;

   logic               pv;
   logic               c_rd_pri, c_rd_ali, c_wr_ack;
   logic [NUM_EVT-1:0] s_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pv <= 1'b0;
      else        pv <= 1'b1;
   end

   assign c_rd_pri = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
   assign c_rd_ali = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_ALIAS));
   assign c_wr_ack = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(OFS_ACK));
   assign s_evt    = stat[NUM_EVT-1:0];

   // R1
   reset_vals_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (stat == '0 && mask == '1 && !irq_o));

   // R2 R8
   evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_in != '0) |=> ((s_evt & $past(evt_in)) == $past(evt_in)));

   // R3
   pri_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_rd_pri |=> (s_evt == $past(evt_in)));

   // R4
   alias_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_rd_ali |=> (s_evt == ($past(s_evt) | $past(evt_in))));

   // R7
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_wr_ack |=> ((s_evt & $past(ack_data) & ~$past(evt_in)) == '0));

   // R6
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '1) |=> !irq_o);

   if (LVL_REG) begin : g_lvl_chk
      // R5
      lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pv |-> (stat[STAT_W-1:NUM_EVT] == $past(lvl_in)));
   end else begin : g_lvl_comb
      // R5
      lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pv |-> (stat[STAT_W-1:NUM_EVT] == lvl_in));
   end

endmodule

bind irq_status_agg irq_status_agg_chk #(
   .ADDR_W(ADDR_W), .NUM_EVT(NUM_EVT), .NUM_LVL(NUM_LVL), .LVL_REG(LVL_REG),
   .OFS_STAT(OFS_STAT), .OFS_ACK(OFS_ACK), .OFS_ALIAS(OFS_ALIAS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .lvl_in(lvl_in),
   .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .ack_data(bus_wdata[NUM_EVT-1:0]), .irq_o(irq_o),
   .stat(stat_w), .mask(mask_q)
);

// File: tb/irq_status_agg_test.sv
`timescale 1ns/1ps
module irq_status_agg_test;

   localparam int DATA_W = 32;
   localparam int ADDR_W = 8;
   localparam int NE     = 7;
   localparam int NL     = 9;
   localparam int SW     = NE + NL;
   localparam logic [ADDR_W-1:0] A_STAT = 8'h00, A_MASK = 8'h04,
                                 A_ACK  = 8'h08, A_ALI  = 8'h0C, A_NONE = 8'h20;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NE-1:0]     evt_in = '0;
   logic [NL-1:0]     lvl_in = '0;
   logic              bus_sel = 1'b0, bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic              irq_o;

   int  n_chk = 0, n_fail = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   irq_status_agg uut (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .lvl_in(lvl_in),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   // Behavioural reference model
   logic [NE-1:0]     m_evt;
   logic [NL-1:0]     m_lvl;
   logic [SW-1:0]     m_mask;
   logic [DATA_W-1:0] m_rdata;
   logic              m_irq;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_evt <= '0; m_lvl <= '0; m_mask <= '1; m_rdata <= '0; m_irq <= 1'b0;
      end else begin
         logic [NE-1:0] clr;
         logic [SW-1:0] word;
         word  = {m_lvl, m_evt};
         clr   = '0;
         m_irq <= ((word & ~m_mask) != '0);
         if (bus_sel && !bus_wr) begin
            if (bus_addr == A_STAT) clr = '1;
            if (bus_addr == A_STAT || bus_addr == A_ALI) m_rdata <= DATA_W'(word);
            else if (bus_addr == A_MASK)                 m_rdata <= DATA_W'(m_mask);
            else                                         m_rdata <= '0;
         end
         if (bus_sel && bus_wr && bus_addr == A_ACK)  clr = bus_wdata[NE-1:0];
         if (bus_sel && bus_wr && bus_addr == A_MASK) m_mask <= bus_wdata[SW-1:0];
         m_evt <= (m_evt & ~clr) | evt_in;
         m_lvl <= lvl_in;
      end
   end

   task automatic chk(input string tag, input logic [DATA_W-1:0] act,
                      input logic [DATA_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R9 irq vs model", DATA_W'(irq_o), DATA_W'(m_irq));
         chk("R3 rdata vs model", bus_rdata, m_rdata);
      end
   end

   // One bus cycle with optional event pulse; called at a falling edge
   task automatic cyc(input logic sel, input logic wr, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d, input logic [NE-1:0] e);
      bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d; evt_in = e;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; evt_in = '0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, '0, '0, '0);
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a);
      cyc(1'b1, 1'b0, a, '0, '0);
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      cyc(1'b1, 1'b1, a, d, '0);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R2 watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset values
      chk("R1 irq after reset", DATA_W'(irq_o), '0);
      chk("R1 rdata after reset", bus_rdata, '0);
      rd(A_ALI);  chk("R1 status after reset", bus_rdata, '0);
      rd(A_MASK); chk("R1 R10 mask after reset", bus_rdata, 32'h0000_FFFF);

      // R2 R4: event latched, alias read keeps it
      cyc(1'b0, 1'b0, '0, '0, 7'h04);
      idle(2);
      rd(A_ALI); chk("R4 alias read", bus_rdata, 32'h4);
      rd(A_ALI); chk("R2 R4 alias again", bus_rdata, 32'h4);
      // R3: primary read returns then clears
      rd(A_STAT); chk("R3 primary read", bus_rdata, 32'h4);
      rd(A_ALI);  chk("R3 cleared after primary", bus_rdata, 32'h0);
      rd(A_NONE); chk("R3 unused offset", bus_rdata, 32'h0);

      // R5: level bits follow, survive reads and acks
      lvl_in = 9'h001;
      idle(1);
      rd(A_STAT); chk("R5 level set", bus_rdata, 32'h80);
      rd(A_STAT); chk("R5 level survives read", bus_rdata, 32'h80);
      wr(A_ACK, 32'hFFFF_FF80);
      rd(A_ALI);  chk("R7 R5 ack hi bits no effect", bus_rdata, 32'h80);
      lvl_in = 9'h000;
      idle(1);
      rd(A_ALI);  chk("R5 level cleared by source", bus_rdata, 32'h0);

      // R6: masked event recorded, no irq
      cyc(1'b0, 1'b0, '0, '0, 7'h02);
      idle(3);
      chk("R6 masked irq low", DATA_W'(irq_o), '0);
      rd(A_ALI); chk("R6 masked status recorded", bus_rdata, 32'h2);
      // R9 R10: unmask raises irq
      wr(A_MASK, 32'h0000_FFFD);
      idle(2);
      chk("R9 irq after unmask", DATA_W'(irq_o), 32'h1);
      rd(A_MASK); chk("R10 mask readback", bus_rdata, 32'h0000_FFFD);

      // R7: zero ack keeps, one ack clears
      wr(A_ACK, 32'h0);
      idle(1);
      rd(A_ALI); chk("R7 zero ack no effect", bus_rdata, 32'h2);
      wr(A_ACK, 32'h2);
      idle(2);
      rd(A_ALI); chk("R7 ack clears", bus_rdata, 32'h0);
      chk("R9 irq falls after ack", DATA_W'(irq_o), '0);

      // R8: event during primary read, and during ack
      cyc(1'b1, 1'b0, A_STAT, '0, 7'h08);
      rd(A_ALI); chk("R8 event beats read clear", bus_rdata, 32'h8);
      cyc(1'b1, 1'b1, A_ACK, 32'h08, 7'h08);
      rd(A_ALI); chk("R8 event beats ack", bus_rdata, 32'h8);
      wr(A_ACK, 32'h7F);
      rd(A_ALI); chk("R7 ack all", bus_rdata, 32'h0);

      // Mixed traffic for the per-cycle model compare
      wr(A_MASK, 32'h0000_0000);
      for (int k = 0; k < 40; k++) begin
         cyc(1'b1, k[0], (k % 3 == 0) ? A_STAT : ((k % 3 == 1) ? A_ALI : A_ACK),
             DATA_W'(k * 5), NE'(k * 3));
         lvl_in = NL'(k * 7);
      end
      idle(3);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule